// File: doc/BRIEF.md
# Synchronous System Bus with Region Decode

This block joins a single bus master to two targets over a clocked, fixed-latency bus. The first target is a 128-word memory. The second is an I/O unit with eight ports, and each port has an output register and an input pin group. The master raises a one-cycle `start` strobe with a direction bit, an 8-bit address and write data. The bus captures this request on that clock edge. In the following cycle the bus decodes which target owns the address, and the target acts at the end of that cycle. In the cycle after that, the bus returns an acknowledge pulse together with any read data.

The top address bit picks the target. Addresses 0x00 to 0x7F reach the memory, where the low seven bits give the word. Addresses 0x80 to 0xFF reach the I/O unit, where the low three bits give the port and bits 6..3 are ignored, so every upper offset maps onto one of the eight ports. Writes follow the same timing as reads.

The request side follows valid/ready rules. `start` acts as valid, and a request is taken only on a clock edge where `start` and `ready` are both high. While `ready` is low, the bus drops `start` and does not queue it. The master does not need to hold a request that was accepted, and it may change `addr`, `wr` and `wdata` after the accepting edge. The response side has no back-pressure: `ack` lasts exactly one cycle, and `rdata` is meaningful only while `ack` is high.

Top module: `sync_sysbus`

## Requirements
- R1: After reset, `ready` is 1, `ack` is 0, `rdata` is 0 and every I/O port output register is 0.
- R2: A request accepted on edge E (`start` and `ready` both high) produces `ack` high in the cycle after edge E+1. `ack` stays high for exactly one cycle and falls after edge E+2.
- R3: A `start` seen while `ready` is low is ignored. It causes no extra `ack` and no write to either target.
- R4: When address bit 7 is 0, the access goes to memory word `addr[6:0]`. A write (`wr`=1) stores `wdata` there. A read (`wr`=0) returns the most recently written value of that word on `rdata` in the `ack` cycle.
- R5: When address bit 7 is 1, the access goes to I/O port `addr[2:0]`, and `addr[6:3]` has no effect on which port is reached.
- R6: An I/O write places `wdata` on `ext_out[8p+7:8p]` for port p, and the new value is visible in the `ack` cycle. An I/O read returns `ext_in[8p+7:8p]` in the `ack` cycle.
- R7: `rdata` is 0 in every cycle where `ack` is low, and it is also 0 in the `ack` cycle of a write.
- R8: `ready` goes low on the cycle after an accepted request, stays low through the `ack` cycle, and is high again in the cycle after `ack`.
- R9: A memory access does not change `ext_out`, and an I/O port register changes only on an I/O write to that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every bus event starts at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe (valid) |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Bit 7 selects the region; the low bits select the word or port |
| wdata | input | 8 | Write data, sampled together with the address |
| ready | output | 1 | High when a new request can be accepted |
| ack | output | 1 | One-cycle transfer acknowledge |
| rdata | output | 8 | Read data, valid only while `ack` is high |
| ext_in | input | 64 | I/O port input pins, port p at bits 8p+7:8p |
| ext_out | output | 64 | I/O port output registers, port p at bits 8p+7:8p |

## Verification
Each request is driven half a cycle before its accepting edge. After one more edge, the bench checks that `ack` and `ready` are low and `rdata` is 0. After a second edge, it checks `ack`, `rdata` and `ext_out` against values computed from its own memory and port model. After a third edge, it checks that `ack` is low and `ready` is high. All samples are taken on the falling edge, so each one lands in exactly the cycle where a result is due. Some transfers inject a conflicting write strobe while the bus is busy. A later read of the targeted location then shows that the injected write had no effect. The address and data inputs are also scrambled after acceptance, to check that the bus holds the captured request.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_DECODE  = 2'd1,
    PH_RESPOND = 2'd2
  } phase_e;
endpackage

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              ack,
  output logic              mem_acc,
  output logic              io_acc,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] wdata_q
);
  localparam int REGION_BIT = ADDR_W - 1;

  phase_e ph_q, ph_d;
  logic   accept;

  assign accept = start && (ph_q == PH_IDLE);

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE:    if (accept) ph_d = PH_DECODE;
      PH_DECODE:  ph_d = PH_RESPOND;
      PH_RESPOND: ph_d = PH_IDLE;
      default:    ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept) begin
        addr_q  <= addr;
        wr_q    <= wr;
        wdata_q <= wdata;
      end
    end
  end

  assign ready   = (ph_q == PH_IDLE);
  assign ack     = (ph_q == PH_RESPOND);
  assign mem_acc = (ph_q == PH_DECODE) && !addr_q[REGION_BIT];
  assign io_acc  = (ph_q == PH_DECODE) &&  addr_q[REGION_BIT];

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);  // R2
  AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> ##1 ack);  // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);  // R8
  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ready);  // R8
endmodule

// File: rtl/sbus_mem.sv
module sbus_mem #(
  parameter int DATA_W = 8,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              acc,
  input  logic              wr,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (acc) begin
      if (wr) begin
        mem_q[idx] <= wdata;
        rd_q       <= '0;
      end else begin
        rd_q <= mem_q[idx];
      end
    end
  end

  assign rd = rd_q;
endmodule

// File: rtl/sbus_io.sv
module sbus_io #(
  parameter int DATA_W = 8,
  parameter int PORTS  = 8,
  parameter int IW     = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc,
  input  logic                    wr,
  input  logic [IW-1:0]           idx,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [PORTS*DATA_W-1:0] pins_in,
  output logic [PORTS*DATA_W-1:0] pins_out,
  output logic [DATA_W-1:0]       rd
);
  logic [PORTS-1:0][DATA_W-1:0] port_q;
  logic [PORTS-1:0][DATA_W-1:0] in_arr;
  logic [DATA_W-1:0]            rd_q;

  for (genvar gp = 0; gp < PORTS; gp++) begin : g_port
    assign in_arr[gp]                        = pins_in[gp*DATA_W +: DATA_W];
    assign pins_out[gp*DATA_W +: DATA_W]     = port_q[gp];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      rd_q   <= '0;
    end else if (acc) begin
      if (wr) begin
        port_q[idx] <= wdata;
        rd_q        <= '0;
      end else begin
        rd_q <= in_arr[idx];
      end
    end
  end

  assign rd = rd_q;

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && wr) |=> $stable(port_q));  // R9
endmodule

// File: rtl/sync_sysbus.sv
module sync_sysbus #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int IO_PORTS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic                       ready,
  output logic                       ack,
  output logic [DATA_W-1:0]          rdata,
  input  logic [IO_PORTS*DATA_W-1:0] ext_in,
  output logic [IO_PORTS*DATA_W-1:0] ext_out
);
  localparam int MEM_AW = ADDR_W - 1;
  localparam int IO_IW  = $clog2(IO_PORTS);

  logic              mem_acc, io_acc, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, mem_rd, io_rd;

  sbus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr),
    .wdata(wdata), .ready(ready), .ack(ack), .mem_acc(mem_acc),
    .io_acc(io_acc), .addr_q(addr_q), .wr_q(wr_q), .wdata_q(wdata_q)
  );

  sbus_mem #(.DATA_W(DATA_W), .AW(MEM_AW)) u_mem (
    .clk(clk), .acc(mem_acc), .wr(wr_q), .idx(addr_q[MEM_AW-1:0]),
    .wdata(wdata_q), .rd(mem_rd)
  );

  sbus_io #(.DATA_W(DATA_W), .PORTS(IO_PORTS), .IW(IO_IW)) u_io (
    .clk(clk), .rst_n(rst_n), .acc(io_acc), .wr(wr_q),
    .idx(addr_q[IO_IW-1:0]), .wdata(wdata_q), .pins_in(ext_in),
    .pins_out(ext_out), .rd(io_rd)
  );

  assign rdata = ack ? (addr_q[ADDR_W-1] ? io_rd : mem_rd) : '0;

  AST_ACCESS_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_acc || io_acc) |=> ack);  // R2
endmodule

// File: tb/sync_sysbus_bench.sv
module sync_sysbus_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, ack;
  logic [7:0]  rdata;
  logic [63:0] ext_in = '0;
  logic [63:0] ext_out;

  logic [7:0]      mem_m [128];
  logic [7:0][7:0] io_m;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sync_sysbus u_sync_sysbus (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr),
    .wdata(wdata), .ready(ready), .ack(ack), .rdata(rdata),
    .ext_in(ext_in), .ext_out(ext_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    return a[7] ? ext_in[a[2:0]*8 +: 8] : mem_m[a[6:0]];
  endfunction

  // one transfer; optional injected write strobe while busy (must be ignored)
  task automatic xfer(input logic w, input logic [7:0] a, input logic [7:0] d,
                      input logic inj, input logic [7:0] ia, input logic [7:0] id);
    logic [7:0] exp_rd;
    exp_rd = w ? 8'h00 : exp_read(a);
    start = 1'b1; wr = w; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    if (inj) begin
      start = 1'b1; wr = 1'b1; addr = ia; wdata = id;
    end else begin
      start = 1'b0; wr = $urandom() % 2 == 0; addr = 8'($urandom()); wdata = 8'($urandom());
    end
    chk("R8 ready low in decode cycle", {63'd0, ready}, 64'd0);
    chk("R2 ack low in decode cycle", {63'd0, ack}, 64'd0);
    chk("R7 rdata zero without ack", {56'd0, rdata}, 64'd0);
    if (w) begin
      if (a[7]) io_m[a[2:0]] = d;
      else mem_m[a[6:0]] = d;
    end
    @(posedge clk); @(negedge clk);
    chk("R2 ack high two edges after accept", {63'd0, ack}, 64'd1);
    chk("R8 ready low in ack cycle", {63'd0, ready}, 64'd0);
    if (w) chk("R7 rdata zero on write ack", {56'd0, rdata}, 64'd0);
    else if (a[7]) chk("R5 R6 io read data", {56'd0, rdata}, {56'd0, exp_rd});
    else chk("R4 memory read data", {56'd0, rdata}, {56'd0, exp_rd});
    chk("R6 R9 ext_out matches port model", ext_out, io_m);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk("R2 ack is a single-cycle pulse", {63'd0, ack}, 64'd0);
    chk("R8 ready back after ack", {63'd0, ready}, 64'd1);
    chk("R7 rdata zero after ack", {56'd0, rdata}, 64'd0);
    chk("R3 R9 ext_out unchanged by ignored start", ext_out, io_m);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] rd_unused;
    void'($urandom(32'd1357));
    io_m = '0;
    ext_in = {$urandom(), $urandom()};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", {63'd0, ready}, 64'd1);
    chk("R1 ack after reset", {63'd0, ack}, 64'd0);
    chk("R1 rdata after reset", {56'd0, rdata}, 64'd0);
    chk("R1 ext_out after reset", ext_out, 64'd0);
    rd_unused = 8'd0;

    // R4 fill memory so the model is complete
    for (int i = 0; i < 128; i++) xfer(1'b1, 8'(i), 8'($urandom()), 1'b0, 8'd0, 8'd0);
    // R4 boundaries of memory region
    xfer(1'b0, 8'h00, 8'd0, 1'b0, 8'd0, 8'd0);
    xfer(1'b0, 8'h7F, 8'd0, 1'b0, 8'd0, 8'd0);
    // R5 R6 I/O boundaries and aliasing
    xfer(1'b1, 8'h80, 8'hA5, 1'b0, 8'd0, 8'd0);
    xfer(1'b1, 8'hFF, 8'h3C, 1'b0, 8'd0, 8'd0);
    xfer(1'b1, 8'hC3, 8'h77, 1'b0, 8'd0, 8'd0);
    chk("R5 alias 0xC3 reaches port 3", {56'd0, ext_out[31:24]}, 64'h77);
    xfer(1'b0, 8'hBB, 8'd0, 1'b0, 8'd0, 8'd0);
    xfer(1'b0, 8'h80, 8'd0, 1'b0, 8'd0, 8'd0);
    // R3 injected strobes while busy: memory target then I/O target
    xfer(1'b0, 8'h10, 8'd0, 1'b1, 8'h10, ~mem_m[16]);
    xfer(1'b0, 8'h10, 8'd0, 1'b0, 8'd0, 8'd0);
    xfer(1'b1, 8'h05, 8'h11, 1'b1, 8'h82, 8'hEE);
    chk("R3 R9 port 2 untouched by ignored write", {56'd0, ext_out[23:16]}, {56'd0, io_m[2]});
    // R9 memory write leaves ports alone
    xfer(1'b1, 8'h7F, 8'h5A, 1'b0, 8'd0, 8'd0);
    xfer(1'b0, 8'h7F, 8'd0, 1'b0, 8'd0, 8'd0);

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      logic       w, inj;
      logic [7:0] a;
      w   = ($urandom() % 3) == 0;
      a   = 8'($urandom());
      inj = ($urandom() % 4) == 0;
      if (($urandom() % 8) == 0) ext_in = {$urandom(), $urandom()};
      xfer(w, a, 8'($urandom()), inj, 8'($urandom()), 8'($urandom()));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule